// File: doc/BRIEF.md
# Short Conditional Branch Resolver

This block takes the two bytes of a short conditional jump, the address at which the opcode sits, and the current arithmetic flags. It decides whether the instruction is a short conditional jump and, if so, whether its condition holds. It then produces the address of the next instruction to fetch. All three results are registered, so they appear one clock after the inputs are sampled.

The opcode byte carries a fixed upper nibble and a 4-bit condition field. The upper three bits of that field pick a flag test, and the lowest bit inverts the result. The 8-bit displacement is signed. It is counted from the end of the two-byte instruction, not from the opcode address.

The condition evaluator is a separate module. Conditional move and conditional set logic, which test flags with the same 4-bit field, can instantiate it directly.

Top module: `scj_resolver`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the outputs after that edge are `jcc_hit`=0, `jcc_taken`=0 and `next_ip`=0.
- R2: `jcc_hit` is 1 exactly when bits [7:4] of the sampled `op_byte` equal 4'b0111 (opcodes 0x70 to 0x7F).
- R3: For a detected jump whose condition fails, `next_ip` equals `op_addr` + 2.
- R4: For a detected jump whose condition holds, `next_ip` equals `op_addr` + 2 + the sign-extended `disp_byte`.
- R5: The condition field is `op_byte[3:0]`. Its upper three bits select the base test: 000 overflow, 001 carry, 010 zero, 011 carry OR zero, 100 sign, 101 parity, 110 sign XOR overflow, 111 zero OR (sign XOR overflow).
- R6: When `op_byte[0]` is 1, `jcc_taken` is the inverse of the result the same upper three bits give with `op_byte[0]` = 0 under the same flags.
- R7: For an opcode outside 0x70 to 0x7F, `jcc_taken` is 0 and `next_ip` equals `op_addr` + 1. The displacement and flags have no effect.
- R8: All address arithmetic wraps modulo 2^32, both forward past 0xFFFFFFFF and backward below 0.
- R9: Each output is registered. The values seen after rising edge k depend only on the inputs sampled at edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_byte | input | 8 | First instruction byte |
| disp_byte | input | 8 | Second instruction byte, signed displacement |
| op_addr | input | 32 | Address of the first instruction byte |
| f_carry | input | 1 | Carry flag |
| f_zero | input | 1 | Zero flag |
| f_sign | input | 1 | Sign flag |
| f_ovf | input | 1 | Overflow flag |
| f_parity | input | 1 | Parity flag |
| jcc_hit | output | 1 | Opcode is a short conditional jump |
| jcc_taken | output | 1 | Jump condition holds |
| next_ip | output | 32 | Address of the next instruction |

## Verification
The hardest cases to reach are the compound tests: below-or-equal, less and less-or-equal. Each can be satisfied by more than one flag, and each needs the sign and overflow flags to disagree or agree on purpose. The vector table therefore sets up several of these cases, each aimed at one flag combination. A second sweep gives every base test the same four flag patterns, once with the low condition bit clear and once with it set, and confirms that the two results are always opposite. Displacements of +127, -128 and -5, together with opcode addresses close to both ends of the 32-bit range, exercise the sign extension and the wrap-around.

// File: rtl/scj_pkg.sv
package scj_pkg;
  localparam int OPC_W   = 8;
  localparam int COND_W  = 4;
  localparam int GRP_W   = OPC_W - COND_W;
  localparam logic [GRP_W-1:0] SHORT_JCC_GRP = 4'b0111;
  localparam int SHORT_LEN = 2;
  localparam int OTHER_LEN = 1;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } flags_t;

  typedef enum logic [2:0] {
    T_OVF   = 3'd0,
    T_CARRY = 3'd1,
    T_ZERO  = 3'd2,
    T_BE    = 3'd3,
    T_SIGN  = 3'd4,
    T_PAR   = 3'd5,
    T_LT    = 3'd6,
    T_LE    = 3'd7
  } base_test_e;
endpackage

// File: rtl/scj_cond_eval.sv
module scj_cond_eval
  import scj_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  flags_t            flags,
  output logic              met
);
  base_test_e sel;
  logic       base;

  always_comb begin
    sel = base_test_e'(cond[COND_W-1:1]);
    unique case (sel)
      T_OVF:   base = flags.of;
      T_CARRY: base = flags.cf;
      T_ZERO:  base = flags.zf;
      T_BE:    base = flags.cf | flags.zf;
      T_SIGN:  base = flags.sf;
      T_PAR:   base = flags.pf;
      T_LT:    base = flags.sf ^ flags.of;
      T_LE:    base = flags.zf | (flags.sf ^ flags.of);
      default: base = 1'b0;
    endcase
    met = base ^ cond[0];
  end
endmodule

// File: rtl/scj_op_match.sv
module scj_op_match
  import scj_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  output logic              is_jcc,
  output logic [COND_W-1:0] cond
);
  always_comb begin
    is_jcc = (opcode[OPC_W-1:COND_W] == SHORT_JCC_GRP);
    cond   = opcode[COND_W-1:0];
  end
endmodule

// File: rtl/scj_ip_calc.sv
module scj_ip_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic              is_jcc,
  input  logic              take,
  output logic [ADDR_W-1:0] next_addr
);
  import scj_pkg::*;
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] fall_thru;
  logic [ADDR_W-1:0] len_add;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    len_add   = is_jcc ? ADDR_W'(SHORT_LEN) : ADDR_W'(OTHER_LEN);
    fall_thru = base_addr + len_add;
    next_addr = (is_jcc && take) ? (fall_thru + disp_ext) : fall_thru;
  end
endmodule

// File: rtl/scj_resolver.sv
module scj_resolver_chk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        op_byte,
  input logic [DISP_W-1:0] disp_byte,
  input logic [ADDR_W-1:0] op_addr,
  input logic              jcc_hit,
  input logic              jcc_taken,
  input logic [ADDR_W-1:0] next_ip
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!jcc_hit && !jcc_taken && next_ip == '0));

  // R2
  detect_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (jcc_hit == ($past(op_byte[7:4]) == 4'b0111)));

  // R7
  no_take_outside_chk: assert property (@(posedge clk) disable iff (rst)
    !jcc_hit |-> !jcc_taken);

  // R7
  other_ip_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !jcc_hit) |-> (next_ip == $past(op_addr) + ADDR_W'(1)));

  // R3
  fall_ip_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && jcc_hit && !jcc_taken) |-> (next_ip == $past(op_addr) + ADDR_W'(2)));

  // R4
  taken_ip_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && jcc_taken) |->
      (next_ip == $past(op_addr) + ADDR_W'(2) +
        {{(ADDR_W-DISP_W){$past(disp_byte[DISP_W-1])}}, $past(disp_byte)}));
endmodule

module scj_resolver #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        op_byte,
  input  logic [DISP_W-1:0] disp_byte,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              f_carry,
  input  logic              f_zero,
  input  logic              f_sign,
  input  logic              f_ovf,
  input  logic              f_parity,
  output logic              jcc_hit,
  output logic              jcc_taken,
  output logic [ADDR_W-1:0] next_ip
);
  import scj_pkg::*;

  flags_t            flags;
  logic              is_jcc;
  logic [COND_W-1:0] cond;
  logic              met;
  logic              take_d;
  logic [ADDR_W-1:0] next_d;

  assign flags = '{cf: f_carry, zf: f_zero, sf: f_sign, of: f_ovf, pf: f_parity};

  scj_op_match u_match (
    .opcode (op_byte),
    .is_jcc (is_jcc),
    .cond   (cond)
  );

  scj_cond_eval u_cond (
    .cond  (cond),
    .flags (flags),
    .met   (met)
  );

  assign take_d = is_jcc & met;

  scj_ip_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ip (
    .base_addr (op_addr),
    .disp      (disp_byte),
    .is_jcc    (is_jcc),
    .take      (take_d),
    .next_addr (next_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      jcc_hit   <= 1'b0;
      jcc_taken <= 1'b0;
      next_ip   <= '0;
    end else begin
      jcc_hit   <= is_jcc;
      jcc_taken <= take_d;
      next_ip   <= next_d;
    end
  end
endmodule

bind scj_resolver scj_resolver_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_byte   (op_byte),
  .disp_byte (disp_byte),
  .op_addr   (op_addr),
  .jcc_hit   (jcc_hit),
  .jcc_taken (jcc_taken),
  .next_ip   (next_ip)
);

// File: tb/tb_scj_resolver.sv
module tb_scj_resolver;
  localparam int NV = 26;
  localparam int VW = 87;
  // fields: op[86:79] disp[78:71] addr[70:39] flags{cf,zf,sf,of,pf}[38:34] hit[33] tk[32] ip[31:0]
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'h74, 8'h10, 32'h0000_1000, 5'b01000, 1'b1, 1'b1, 32'h0000_1012},
    {8'h75, 8'h10, 32'h0000_1000, 5'b01000, 1'b1, 1'b0, 32'h0000_1002},
    {8'h75, 8'hFB, 32'h0040_1013, 5'b00000, 1'b1, 1'b1, 32'h0040_1010},
    {8'h70, 8'h7F, 32'h0000_2000, 5'b00010, 1'b1, 1'b1, 32'h0000_2081},
    {8'h71, 8'h7F, 32'h0000_2000, 5'b00010, 1'b1, 1'b0, 32'h0000_2002},
    {8'h72, 8'h80, 32'h0000_3000, 5'b10000, 1'b1, 1'b1, 32'h0000_2F82},
    {8'h73, 8'h04, 32'h0000_3000, 5'b00000, 1'b1, 1'b1, 32'h0000_3006},
    {8'h76, 8'h01, 32'h0000_0010, 5'b01000, 1'b1, 1'b1, 32'h0000_0013},
    {8'h77, 8'h02, 32'h0000_0010, 5'b00000, 1'b1, 1'b1, 32'h0000_0014},
    {8'h77, 8'h02, 32'h0000_0010, 5'b10000, 1'b1, 1'b0, 32'h0000_0012},
    {8'h78, 8'h00, 32'h0000_0050, 5'b00100, 1'b1, 1'b1, 32'h0000_0052},
    {8'h79, 8'h00, 32'h0000_0050, 5'b00100, 1'b1, 1'b0, 32'h0000_0052},
    {8'h7A, 8'h08, 32'h0000_0060, 5'b00001, 1'b1, 1'b1, 32'h0000_006A},
    {8'h7B, 8'h08, 32'h0000_0060, 5'b00000, 1'b1, 1'b1, 32'h0000_006A},
    {8'h7C, 8'h10, 32'h0000_0100, 5'b00100, 1'b1, 1'b1, 32'h0000_0112},
    {8'h7C, 8'h10, 32'h0000_0100, 5'b00110, 1'b1, 1'b0, 32'h0000_0102},
    {8'h7D, 8'h10, 32'h0000_0100, 5'b00110, 1'b1, 1'b1, 32'h0000_0112},
    {8'h7E, 8'h20, 32'h0000_0200, 5'b00010, 1'b1, 1'b1, 32'h0000_0222},
    {8'h7F, 8'h20, 32'h0000_0200, 5'b00110, 1'b1, 1'b1, 32'h0000_0222},
    {8'h7F, 8'h20, 32'h0000_0200, 5'b01000, 1'b1, 1'b0, 32'h0000_0202},
    // R8 forward wrap
    {8'h74, 8'h05, 32'hFFFF_FFFF, 5'b01000, 1'b1, 1'b1, 32'h0000_0006},
    // R8 backward wrap
    {8'h75, 8'hF0, 32'h0000_0000, 5'b00000, 1'b1, 1'b1, 32'hFFFF_FFF2},
    // R7 non-jump opcodes, flags all set
    {8'h90, 8'h40, 32'h0000_1234, 5'b11111, 1'b0, 1'b0, 32'h0000_1235},
    {8'h6F, 8'h40, 32'hFFFF_FFFF, 5'b11111, 1'b0, 1'b0, 32'h0000_0000},
    {8'h80, 8'h40, 32'h0000_0500, 5'b11111, 1'b0, 1'b0, 32'h0000_0501},
    // R8 not-taken wrap
    {8'h74, 8'h10, 32'hFFFF_FFFE, 5'b00000, 1'b1, 1'b0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  op_byte = '0;
  logic [7:0]  disp_byte = '0;
  logic [31:0] op_addr = '0;
  logic        f_carry = 1'b0, f_zero = 1'b0, f_sign = 1'b0, f_ovf = 1'b0, f_parity = 1'b0;
  logic        jcc_hit, jcc_taken;
  logic [31:0] next_ip;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  scj_resolver dut (
    .clk(clk), .rst(rst), .op_byte(op_byte), .disp_byte(disp_byte), .op_addr(op_addr),
    .f_carry(f_carry), .f_zero(f_zero), .f_sign(f_sign), .f_ovf(f_ovf), .f_parity(f_parity),
    .jcc_hit(jcc_hit), .jcc_taken(jcc_taken), .next_ip(next_ip)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] d, input logic [31:0] a,
                       input logic [4:0] fl);
    op_byte = op; disp_byte = d; op_addr = a;
    {f_carry, f_zero, f_sign, f_ovf, f_parity} = fl;
  endtask

  initial begin
    logic tk_even;
    // R1: reset with a taken jump on the inputs
    drive(8'h74, 8'h10, 32'h1000, 5'b01000);
    @(negedge clk); @(negedge clk);
    check("R1 hit", {31'd0, jcc_hit}, 32'd0);
    check("R1 taken", {31'd0, jcc_taken}, 32'd0);
    check("R1 ip", next_ip, 32'd0);
    rst = 1'b0;

    // R2 R3 R4 R5 R7 R8 R9: table walk, one edge per vector
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][86:79], VEC[i][78:71], VEC[i][70:39], VEC[i][38:34]);
      @(negedge clk);
      check("R2 hit", {31'd0, jcc_hit}, {31'd0, VEC[i][33]});
      check("R5 taken", {31'd0, jcc_taken}, {31'd0, VEC[i][32]});
      if (!VEC[i][33])      check("R7 ip", next_ip, VEC[i][31:0]);
      else if (VEC[i][32])  check("R4 ip", next_ip, VEC[i][31:0]);
      else                  check("R3 ip", next_ip, VEC[i][31:0]);
    end

    // R6: low condition bit inverts every base test
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 4; p++) begin
        logic [4:0] fl;
        fl = (p == 0) ? 5'b00000 : (p == 1) ? 5'b11111 : (p == 2) ? 5'b01010 : 5'b10101;
        drive({4'b0111, 3'(b), 1'b0}, 8'h00, 32'h100, fl);
        @(negedge clk);
        tk_even = jcc_taken;
        drive({4'b0111, 3'(b), 1'b1}, 8'h00, 32'h100, fl);
        @(negedge clk);
        check("R6 invert", {31'd0, jcc_taken}, {31'd0, ~tk_even});
      end
    end

    // R1: reset asserted mid-stream clears the outputs after one edge
    drive(8'h7B, 8'h08, 32'h60, 5'b00000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid hit", {31'd0, jcc_hit}, 32'd0);
    check("R1 mid ip", next_ip, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", next_ip, 32'h6A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule